// File: doc/BRIEF.md
# Decoded Register-File ALU Datapath

This block is the execute stage of a small processor. A 16-bit instruction word enters a combinational decoder. The decoder turns it into a control word that steers the rest of the datapath. The control word names the two source registers, the ALU function, the function-unit select (ALU or shifter), the write-back source (function result or external data), the destination register and a load enable.

An eight-entry register file of 8-bit words drives two operand buses. Bus A feeds the ALU. Bus B feeds both the ALU and the shifter. The two buses are also presented to memory as an address and a write-data pair. One instruction completes per clock. Its result is written on the next rising edge, and four status flags describe the ALU result of the instruction currently applied. A third, independent read port lets a bench or a neighbour observe any register.

Top module: `dp_core`

## Requirements
- R1: An active-low asynchronous reset clears all eight registers to zero. After reset, every register reads 0 on the check port.
- R2: The instruction fields are laid out as follows:
  - bits [15:9]: opcode
  - bits [8:6]: destination register
  - bits [5:3]: A source register
  - bits [2:0]: B source register

  A writing instruction updates only the destination register, at the rising clock edge. For example, 0000101 001 011 010 writes R3 − R2 into R1.
- R3: Opcode 0000101 (subtract) writes (A − B) mod 256. Carry is 1 exactly when A ≥ B unsigned, which means there was no borrow. Overflow is 1 when A and B differ in sign and the result's sign differs from A's.
- R4: Opcode 0000010 (add) writes (A + B) mod 256. Carry is the carry out of bit 7. Overflow is 1 when A and B have the same sign and the result's sign differs from it.
- R5: Opcode 0000001 (increment) writes A + 1, with carry = (A == 0xFF) and overflow = (A == 0x7F). Opcode 0000110 (decrement) writes A − 1, with carry = (A != 0) and overflow = (A == 0x80).
- R6: The logic opcodes are:
  - 0001000: A AND B
  - 0001001: A OR B
  - 0001010: A XOR B
  - 0001011: NOT A

  For all four, carry and overflow are 0.
- R7: Zero is 1 when the 8-bit ALU result is 0, and negative is bit 7 of that result. Opcode 0000000 writes A to the destination. For that opcode and for the shift and load opcodes, the ALU passes A through, so the flags describe A with carry = overflow = 0.
- R8: Opcode 0001101 writes B shifted right by one with zero fill. Opcode 0001110 writes B shifted left by one with zero fill.
- R9: Opcode 0010000 writes the external data input into the destination.
- R10: Any other opcode leaves all eight registers unchanged.
- R11: The memory address equals register A and the memory write data equals register B, in the same cycle the instruction is applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the register write happens on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr | input | 16 | Instruction word for this cycle |
| data_in | input | 8 | External data word written back by the load opcode |
| chk_sel | input | 3 | Register index for the check read port |
| chk_data | output | 8 | Contents of the register chosen by chk_sel |
| mem_addr | output | 8 | Register A value, towards memory |
| mem_wdata | output | 8 | Register B value, towards memory |
| flag_c | output | 1 | Carry out; for subtract and decrement, the inverted borrow |
| flag_n | output | 1 | Negative: bit 7 of the ALU result |
| flag_z | output | 1 | Zero: ALU result equals 0 |
| flag_v | output | 1 | Signed overflow |

## Verification
The signed-overflow and borrow corners occur only when the operand registers hold particular values such as 0x7F, 0x80, 0x00 and 0xFF. The bench therefore first uses the load opcode to seed registers with those values, then aims add, subtract, increment and decrement at them. The claim that unknown opcodes change nothing needs registers that are not already zero, so those instructions are sent only after seeding. The scoreboard compares all eight registers through the check port after every instruction. A long pseudo-random instruction stream, including unknown opcodes, then mixes source and destination aliasing that directed cases would miss.

// File: rtl/dp_pkg.sv
package dp_pkg;
  localparam int DW  = 8;
  localparam int RN  = 8;
  localparam int SW  = $clog2(RN);
  localparam int OPW = 7;
  localparam int IW  = OPW + 3 * SW;

  typedef enum logic [3:0] {
    G_PASSA, G_INC, G_ADD, G_SUB, G_DEC, G_AND, G_OR, G_XOR, G_NOT
  } gsel_e;
  typedef enum logic [1:0] { H_PASSB, H_SHR, H_SHL } hsel_e;
  typedef enum logic { MF_ALU, MF_SHF } mf_e;
  typedef enum logic { MD_FN, MD_MEM } md_e;

  typedef struct packed {
    logic [SW-1:0] asel;
    logic [SW-1:0] bsel;
    logic [SW-1:0] dsel;
    gsel_e         g;
    hsel_e         h;
    mf_e           mf;
    md_e           md;
    logic          ld;
  } ctl_t;

  typedef struct packed {
    logic [DW-1:0] f;
    logic          c;
    logic          v;
    logic          n;
    logic          z;
  } alu_res_t;

  localparam logic [OPW-1:0] OP_MOVA = 7'b0000000;
  localparam logic [OPW-1:0] OP_INC  = 7'b0000001;
  localparam logic [OPW-1:0] OP_ADD  = 7'b0000010;
  localparam logic [OPW-1:0] OP_SUB  = 7'b0000101;
  localparam logic [OPW-1:0] OP_DEC  = 7'b0000110;
  localparam logic [OPW-1:0] OP_AND  = 7'b0001000;
  localparam logic [OPW-1:0] OP_OR   = 7'b0001001;
  localparam logic [OPW-1:0] OP_XOR  = 7'b0001010;
  localparam logic [OPW-1:0] OP_NOT  = 7'b0001011;
  localparam logic [OPW-1:0] OP_SHR  = 7'b0001101;
  localparam logic [OPW-1:0] OP_SHL  = 7'b0001110;
  localparam logic [OPW-1:0] OP_LD   = 7'b0010000;

  // ALU arithmetic: a 9-bit sum gives the carry; subtract adds ~B + 1 so the
  // carry bit is the inverted borrow.
  function automatic alu_res_t alu_calc(gsel_e g, logic [DW-1:0] a, logic [DW-1:0] b);
    alu_res_t      r;
    logic [DW:0]   s;
    logic          sa, sb, sf;
    s   = {1'b0, a};
    r.v = 1'b0;
    unique case (g)
      G_INC: s = {1'b0, a} + {{DW{1'b0}}, 1'b1};
      G_ADD: s = {1'b0, a} + {1'b0, b};
      G_SUB: s = {1'b0, a} + {1'b0, ~b} + {{DW{1'b0}}, 1'b1};
      G_DEC: s = {1'b0, a} + {1'b0, {DW{1'b1}}};
      G_AND: s = {1'b0, a & b};
      G_OR:  s = {1'b0, a | b};
      G_XOR: s = {1'b0, a ^ b};
      G_NOT: s = {1'b0, ~a};
      default: s = {1'b0, a};
    endcase
    sa = a[DW-1];
    sb = b[DW-1];
    sf = s[DW-1];
    unique case (g)
      G_INC: r.v = ~sa & sf;
      G_ADD: r.v = (sa == sb) && (sf != sa);
      G_SUB: r.v = (sa != sb) && (sf != sa);
      G_DEC: r.v = sa & ~sf;
      default: r.v = 1'b0;
    endcase
    r.f = s[DW-1:0];
    r.c = (g inside {G_INC, G_ADD, G_SUB, G_DEC}) ? s[DW] : 1'b0;
    r.n = s[DW-1];
    r.z = (s[DW-1:0] == '0);
    return r;
  endfunction

  function automatic logic [DW-1:0] shift_calc(hsel_e h, logic [DW-1:0] b);
    unique case (h)
      H_SHR:   return {1'b0, b[DW-1:1]};
      H_SHL:   return {b[DW-2:0], 1'b0};
      default: return b;
    endcase
  endfunction
endpackage

// File: rtl/dp_decoder.sv
module dp_decoder
  import dp_pkg::*;
(
  input  logic [IW-1:0] instr,
  output ctl_t          ctl
);
  logic [OPW-1:0] opcode;
  assign opcode = instr[IW-1 -: OPW];

  always_comb begin
    // R2: destination, A source and B source fields, high to low
    ctl.dsel = instr[3*SW-1 -: SW];
    ctl.asel = instr[2*SW-1 -: SW];
    ctl.bsel = instr[SW-1 -: SW];
    ctl.g    = G_PASSA;
    ctl.h    = H_PASSB;
    ctl.mf   = MF_ALU;
    ctl.md   = MD_FN;
    ctl.ld   = 1'b1;
    case (opcode)
      OP_MOVA: ctl.g = G_PASSA;
      OP_INC:  ctl.g = G_INC;
      OP_ADD:  ctl.g = G_ADD;
      OP_SUB:  ctl.g = G_SUB;
      OP_DEC:  ctl.g = G_DEC;
      OP_AND:  ctl.g = G_AND;
      OP_OR:   ctl.g = G_OR;
      OP_XOR:  ctl.g = G_XOR;
      OP_NOT:  ctl.g = G_NOT;
      OP_SHR:  begin ctl.mf = MF_SHF; ctl.h = H_SHR; end
      OP_SHL:  begin ctl.mf = MF_SHF; ctl.h = H_SHL; end
      OP_LD:   ctl.md = MD_MEM;
      default: ctl.ld = 1'b0;
    endcase
  end
endmodule

// File: rtl/dp_regfile.sv
module dp_regfile #(
  parameter int DW = 8,
  parameter int RN = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [$clog2(RN)-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [$clog2(RN)-1:0] raddr_a,
  input  logic [$clog2(RN)-1:0] raddr_b,
  input  logic [$clog2(RN)-1:0] raddr_c,
  output logic [DW-1:0] rdata_a,
  output logic [DW-1:0] rdata_b,
  output logic [DW-1:0] rdata_c
);
  localparam int SW = $clog2(RN);

  logic [RN-1:0][DW-1:0] regs;
  logic [RN-1:0]         wr_hit;

  for (genvar i = 0; i < RN; i++) begin : g_hit
    assign wr_hit[i] = we && (waddr == SW'(i));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      regs <= '0;
    end else begin
      for (int i = 0; i < RN; i++) begin
        if (wr_hit[i]) regs[i] <= wdata;
      end
    end
  end

  assign rdata_a = regs[raddr_a];
  assign rdata_b = regs[raddr_b];
  assign rdata_c = regs[raddr_c];

  p_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> regs[$past(waddr)] == $past(wdata));

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(regs));
endmodule

// File: rtl/dp_fu.sv
module dp_fu
  import dp_pkg::*;
(
  input  gsel_e         g,
  input  hsel_e         h,
  input  mf_e           mf,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  output alu_res_t      alu,
  output logic [DW-1:0] f
);
  logic [DW-1:0] shf;
  assign alu = alu_calc(g, a, b);
  assign shf = shift_calc(h, b);
  assign f   = (mf == MF_SHF) ? shf : alu.f;
endmodule

// File: rtl/dp_core.sv
module dp_core
  import dp_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [15:0]   instr,
  input  logic [7:0]    data_in,
  input  logic [2:0]    chk_sel,
  output logic [7:0]    chk_data,
  output logic [7:0]    mem_addr,
  output logic [7:0]    mem_wdata,
  output logic          flag_c,
  output logic          flag_n,
  output logic          flag_z,
  output logic          flag_v
);
  ctl_t          ctl;
  logic [DW-1:0] bus_a, bus_b, fu_f, wb_data;
  alu_res_t      alu;

  dp_decoder u_dec (.instr(instr), .ctl(ctl));

  dp_regfile #(.DW(DW), .RN(RN)) u_rf (
    .clk(clk), .rst_n(rst_n),
    .we(ctl.ld), .waddr(ctl.dsel), .wdata(wb_data),
    .raddr_a(ctl.asel), .raddr_b(ctl.bsel), .raddr_c(chk_sel),
    .rdata_a(bus_a), .rdata_b(bus_b), .rdata_c(chk_data)
  );

  dp_fu u_fu (
    .g(ctl.g), .h(ctl.h), .mf(ctl.mf),
    .a(bus_a), .b(bus_b), .alu(alu), .f(fu_f)
  );

  assign wb_data   = (ctl.md == MD_MEM) ? data_in : fu_f;
  assign mem_addr  = bus_a;
  assign mem_wdata = bus_b;
  assign flag_c    = alu.c;
  assign flag_n    = alu.n;
  assign flag_z    = alu.z;
  assign flag_v    = alu.v;

  // Signed sum of the operands, used only to cross-check the overflow flag.
  logic signed [DW:0] chk_sum;
  assign chk_sum = $signed({bus_a[DW-1], bus_a}) + $signed({bus_b[DW-1], bus_b});

  p_sub_carry_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.g == G_SUB) |-> (flag_c == (bus_a >= bus_b)));

  p_add_ovf_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.g == G_ADD) |-> (flag_v == (chk_sum[DW] != chk_sum[DW-1])));

  p_inc_carry_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.g == G_INC) |-> (flag_c == (bus_a == {DW{1'b1}})));

  p_logic_cv_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.g inside {G_AND, G_OR, G_XOR, G_NOT}) |-> (!flag_c && !flag_v));
endmodule

// File: tb/dp_core_test.sv
`timescale 1ns/100ps
module dp_core_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] instr = '0;
  logic [7:0]  data_in = '0;
  logic [2:0]  chk_sel = '0;
  logic [7:0]  chk_data, mem_addr, mem_wdata;
  logic        flag_c, flag_n, flag_z, flag_v;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  dp_core uut (
    .clk(clk), .rst_n(rst_n), .instr(instr), .data_in(data_in),
    .chk_sel(chk_sel), .chk_data(chk_data), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .flag_c(flag_c), .flag_n(flag_n),
    .flag_z(flag_z), .flag_v(flag_v)
  );

  typedef struct {
    string            tag;
    bit               fl;
    logic [3:0]       cnzv;
    logic [7:0]       ma;
    logic [7:0]       mw;
    logic [7:0][7:0]  regs;
  } item_t;

  item_t           sb[$];
  logic [7:0][7:0] model;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Independent reference built from the requirements with integer arithmetic.
  task automatic ref_exec(input logic [6:0] op, input logic [7:0] a, input logic [7:0] b,
                          input logic [7:0] din, output bit wen, output logic [7:0] res,
                          output logic [3:0] cnzv, output string tag);
    int ua, ub, sa, sb, r;
    bit c, v;
    logic [7:0] alu;
    ua = a; ub = b;
    sa = (a > 127) ? a - 256 : a;
    sb = (b > 127) ? b - 256 : b;
    c = 0; v = 0; alu = a; wen = 1; res = a; tag = "R7 MOVA";
    case (op)
      7'b0000000: ;
      7'b0000010: begin r = sa + sb; v = (r > 127) || (r < -128); c = (ua + ub) > 255;
                        alu = 8'((ua + ub) % 256); res = alu; tag = "R4 ADD"; end
      7'b0000101: begin r = sa - sb; v = (r > 127) || (r < -128); c = (ua >= ub);
                        alu = 8'((ua - ub + 256) % 256); res = alu; tag = "R3 SUB"; end
      7'b0000001: begin v = (a == 8'h7F); c = (a == 8'hFF); alu = 8'((ua + 1) % 256);
                        res = alu; tag = "R5 INC"; end
      7'b0000110: begin v = (a == 8'h80); c = (a != 8'h00); alu = 8'((ua + 255) % 256);
                        res = alu; tag = "R5 DEC"; end
      7'b0001000: begin alu = a & b; res = alu; tag = "R6 AND"; end
      7'b0001001: begin alu = a | b; res = alu; tag = "R6 OR"; end
      7'b0001010: begin alu = a ^ b; res = alu; tag = "R6 XOR"; end
      7'b0001011: begin alu = ~a; res = alu; tag = "R6 NOT"; end
      7'b0001101: begin res = 8'(ub / 2); tag = "R8 SHR"; end
      7'b0001110: begin res = 8'((ub * 2) % 256); tag = "R8 SHL"; end
      7'b0010000: begin res = din; tag = "R9 LD"; end
      default:    begin wen = 0; tag = "R10 unknown"; end
    endcase
    cnzv = {c, alu[7], alu == 8'h00, v};
  endtask

  task automatic exec(input logic [6:0] op, input int d, input int sa_i, input int sb_i,
                      input logic [7:0] din);
    item_t it;
    bit wen;
    logic [7:0] res;
    @(negedge clk);
    instr   = {op, 3'(d), 3'(sa_i), 3'(sb_i)};
    data_in = din;
    ref_exec(op, model[sa_i], model[sb_i], din, wen, res, it.cnzv, it.tag);
    it.fl = wen;
    it.ma = model[sa_i];
    it.mw = model[sb_i];
    if (wen) model[d] = res;
    it.regs = model;
    sb.push_back(it);
  endtask

  // Monitor: flags and memory ports while the instruction is applied,
  // then all eight registers after the write edge.
  initial begin
    item_t it;
    forever begin
      @(negedge clk);
      #1;
      if (sb.size() > 0) begin
        it = sb.pop_front();
        chk(mem_addr == it.ma, {"R11 mem_addr ", it.tag}, mem_addr, it.ma);
        chk(mem_wdata == it.mw, {"R11 mem_wdata ", it.tag}, mem_wdata, it.mw);
        if (it.fl)
          chk({flag_c, flag_n, flag_z, flag_v} == it.cnzv, {"R7 flags ", it.tag},
              {flag_c, flag_n, flag_z, flag_v}, it.cnzv);
        @(posedge clk);
        #0.5;
        for (int i = 0; i < 8; i++) begin
          chk_sel = 3'(i);
          #0.1;
          chk(chk_data == it.regs[i], {"R2 reg ", it.tag}, chk_data, it.regs[i]);
        end
      end
    end
  end

  task automatic drain;
    while (sb.size() > 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic reset_check;
    for (int i = 0; i < 8; i++) begin
      chk_sel = 3'(i);
      #0.1;
      chk(chk_data == 8'h00, "R1 reset clears", chk_data, 8'h00);
    end
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] lf;
    logic [6:0] ops [13];
    ops = '{7'b0000000, 7'b0000001, 7'b0000010, 7'b0000101, 7'b0000110, 7'b0001000,
            7'b0001001, 7'b0001010, 7'b0001011, 7'b0001101, 7'b0001110, 7'b0010000,
            7'b1111111};
    model = '0;
    repeat (3) @(negedge clk);
    reset_check();
    rst_n = 1'b1;

    // Seed corner values through the load opcode (R9).
    exec(7'b0010000, 0, 0, 0, 8'h7F);
    exec(7'b0010000, 1, 0, 0, 8'h80);
    exec(7'b0010000, 2, 0, 0, 8'h01);
    exec(7'b0010000, 3, 0, 0, 8'hFF);
    exec(7'b0010000, 4, 0, 0, 8'h3C);
    exec(7'b0010000, 5, 0, 0, 8'h00);
    exec(7'b0010000, 6, 0, 0, 8'h55);
    exec(7'b0010000, 7, 0, 0, 8'hA0);
    // R10: unknown opcodes with non-zero registers
    exec(7'b1111111, 0, 3, 2, 8'hEE);
    exec(7'b0000011, 4, 1, 1, 8'hEE);
    exec(7'b0100000, 7, 0, 6, 8'hEE);
    // R4 overflow and carry corners
    exec(7'b0000010, 5, 0, 2, 8'h00);
    exec(7'b0000010, 5, 3, 2, 8'h00);
    exec(7'b0000010, 5, 1, 1, 8'h00);
    // R2 R3 example layout: R1 <= R3 - R2
    exec(7'b0000101, 1, 3, 2, 8'h00);
    exec(7'b0000101, 4, 2, 3, 8'h00);
    exec(7'b0010000, 6, 0, 0, 8'h80);
    exec(7'b0000101, 0, 6, 2, 8'h00);
    exec(7'b0000101, 5, 2, 2, 8'h00);
    // R5 increment and decrement corners
    exec(7'b0010000, 0, 0, 0, 8'h7F);
    exec(7'b0000001, 7, 0, 0, 8'h00);
    exec(7'b0000001, 7, 3, 0, 8'h00);
    exec(7'b0000110, 7, 6, 0, 8'h00);
    exec(7'b0010000, 5, 0, 0, 8'h00);
    exec(7'b0000110, 7, 5, 0, 8'h00);
    // R6 logic
    exec(7'b0001000, 4, 3, 0, 8'h00);
    exec(7'b0001001, 4, 6, 2, 8'h00);
    exec(7'b0001010, 4, 3, 3, 8'h00);
    exec(7'b0001011, 4, 3, 0, 8'h00);
    // R8 shifts, R7 move
    exec(7'b0001101, 2, 0, 3, 8'h00);
    exec(7'b0001110, 2, 0, 3, 8'h00);
    exec(7'b0001110, 2, 0, 6, 8'h00);
    exec(7'b0000000, 1, 6, 0, 8'h00);
    exec(7'b0000000, 1, 5, 0, 8'h00);
    drain();

    // R1: reset after writes
    @(negedge clk);
    rst_n = 1'b0;
    model = '0;
    #0.5;
    reset_check();
    @(negedge clk);
    rst_n = 1'b1;

    // Pseudo-random stream with aliasing and unknown opcodes.
    lf = 16'hACE1;
    for (int n = 0; n < 400; n++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      exec(ops[int'(lf) % 13], int'(lf[2:0]), int'(lf[5:3]), int'(lf[8:6]), lf[15:8] ^ lf[7:0]);
    end
    drain();

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule